// File: doc/BRIEF.md
# Command Completion Counter with Level Interrupt

This block is the per-channel event bookkeeping of a descriptor-driven DMA channel. Each time the descriptor sequencer reports an event, a hardware-owned counter advances. Software owns a second counter of the same width. It writes that counter to record how many events it has handled. The difference between the two is the number of events still waiting. Because software never writes the hardware counter, an acknowledge can never erase an event that arrives during the acknowledge itself.

Both counters and an interrupt-active flag can be read back as one status word. The same word is written to acknowledge. The interrupt output is enabled and given its mode by bits of the channel's general configuration word. In level mode the line stays high for as long as work is pending. In pulse mode it gives one cycle per event. The block also tracks chains. The first event after a chain starts means the command list has been loaded. Each later event means one descriptor has completed, and this is reported on a one-cycle completion strobe.

Top module: `cmd_event_ctr`

## Requirements
- R1: The done counter, read in status bits 5:0, increments by exactly one on the clock edge after each cycle in which `evt_i` is high. It counts modulo 64, so 63 is followed by 0. A write in the same cycle does not cancel the increment.
- R2: `pending_o` always equals (done − processed) mod 64.
- R3: The first event after reset, or after a cycle with `chain_start_i` high, sets `list_loaded_o` and produces no completion. Every later event in the chain raises `cmpl_o` for exactly the following cycle. An event in the same cycle as `chain_start_i` counts as the list-load event of the new chain.
- R4: A write (`reg_wr_i` high) loads the processed counter from write bits 21:16, which read back in status bits 21:16. Write bits 5:0 have no effect on the done counter. Status bits 31:22, 15:9 and 7:6 always read as zero.
- R5: The interrupt-active flag (status bit 8) is set by any event while interrupts are enabled. Interrupts are enabled when configuration bits 29 and 31 are both 1. Otherwise, a write loads the flag from write bit 8. When an enabled event and a write fall in the same cycle, the flag ends up set.
- R6: In level mode (configuration bit 28 = 1), `irq_o` is high exactly when interrupts are enabled and either the interrupt-active flag is set or the done and processed counters differ.
- R7: In pulse mode (configuration bit 28 = 0), `irq_o` is high exactly in the cycle after an event, and only while interrupts are enabled. When interrupts are disabled, `irq_o` is low in either mode.
- R8: After reset, both counters, the interrupt-active flag, `list_loaded_o`, `cmpl_o` and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | One-cycle event pulse from the descriptor sequencer |
| chain_start_i | input | 1 | Marks the start of a new descriptor chain |
| cfg_i | input | 32 | General configuration word (bit 31 list interrupt enable, bit 29 interrupt enable, bit 28 level mode) |
| reg_wr_i | input | 1 | Write strobe for the status word |
| reg_wdata_i | input | 32 | Write data for the status word |
| reg_rdata_o | output | 32 | Status word: done in 5:0, interrupt-active in 8, processed in 21:16 |
| pending_o | output | 6 | Number of unacknowledged events, modulo 64 |
| list_loaded_o | output | 1 | The current chain's list-load event has been seen |
| cmpl_o | output | 1 | One-cycle strobe for each descriptor completion |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land on the same clock edge: a sequencer event and a software acknowledge. In that case the done counter must still advance, and the interrupt-active flag must end up set even though the write clears it. The bench forces this by driving `evt_i` and an acknowledging write together for many consecutive cycles. It also lets random traffic produce the overlap on its own. On every cycle it compares the status word, `pending_o` and `irq_o` against a behavioural model, so any event lost during an acknowledge shows up at once as a wrong done field or a wrong pending count.

// File: rtl/cmd_ctr_pkg.sv
package cmd_ctr_pkg;
  typedef enum logic {IRQ_PULSE = 1'b0, IRQ_LEVEL = 1'b1} irq_mode_e;

  localparam int DONE_LSB_DEF = 0;
  localparam int ACT_BIT_DEF  = 8;
  localparam int PROC_LSB_DEF = 16;
  localparam int CFG_LIST_IEN_DEF = 31;
  localparam int CFG_IEN_DEF      = 29;
  localparam int CFG_LEVEL_DEF    = 28;
endpackage

// File: rtl/done_ctr.sv
module done_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  output logic [CNT_W-1:0] done_o
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     done_o <= '0;
    else if (evt_i) done_o <= bump(done_o);
  end

  // R1
  done_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> done_o == CNT_W'($past(done_o) + CNT_W'(1)));
  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |=> $stable(done_o));
endmodule

// File: rtl/ack_reg.sv
module ack_reg #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] proc_wr_i,
  input  logic             act_wr_i,
  input  logic             set_i,
  output logic [CNT_W-1:0] proc_o,
  output logic             act_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proc_o <= '0;
      act_o  <= 1'b0;
    end else begin
      if (wr_i) proc_o <= proc_wr_i;
      if (set_i)     act_o <= 1'b1;
      else if (wr_i) act_o <= act_wr_i;
    end
  end

  // R5
  act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> act_o);
  // R4
  proc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(proc_o));
endmodule

// File: rtl/chain_trk.sv
module chain_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic start_i,
  output logic loaded_o,
  output logic cmpl_o
);
  logic first_evt;
  assign first_evt = evt_i & (start_i | ~loaded_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_o <= 1'b0;
      cmpl_o   <= 1'b0;
    end else begin
      cmpl_o <= evt_i & ~first_evt;
      if (evt_i)        loaded_o <= 1'b1;
      else if (start_i) loaded_o <= 1'b0;
    end
  end

  // R3
  first_no_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && (start_i || !loaded_o) |=> !cmpl_o && loaded_o);
  // R3
  quiet_no_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |=> !cmpl_o);
endmodule

// File: rtl/irq_gen.sv
module irq_gen
  import cmd_ctr_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             en_i,
  input  irq_mode_e        mode_i,
  input  logic             act_i,
  input  logic [CNT_W-1:0] done_i,
  input  logic [CNT_W-1:0] proc_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] pending_o
);
  function automatic logic [CNT_W-1:0] backlog(input logic [CNT_W-1:0] d,
                                               input logic [CNT_W-1:0] p);
    return d - p;
  endfunction

  logic evt_q;
  logic lvl_req;

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_i;
  end

  assign pending_o = backlog(done_i, proc_i);
  assign lvl_req   = act_i | (pending_o != '0);

  always_comb begin
    irq_o = 1'b0;
    if (en_i) irq_o = (mode_i == IRQ_LEVEL) ? lvl_req : evt_q;
  end

  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && mode_i == IRQ_LEVEL && done_i != proc_i |-> irq_o);
  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !irq_o);
endmodule

// File: rtl/cmd_event_ctr.sv
module cmd_event_ctr
  import cmd_ctr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 6,
  parameter int DONE_LSB = DONE_LSB_DEF,
  parameter int ACT_BIT  = ACT_BIT_DEF,
  parameter int PROC_LSB = PROC_LSB_DEF,
  parameter int CFG_LIST_IEN = CFG_LIST_IEN_DEF,
  parameter int CFG_IEN      = CFG_IEN_DEF,
  parameter int CFG_LEVEL    = CFG_LEVEL_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              chain_start_i,
  input  logic [DATA_W-1:0] cfg_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [CNT_W-1:0]  pending_o,
  output logic              list_loaded_o,
  output logic              cmpl_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] done_w;
  logic [CNT_W-1:0] proc_w;
  logic             act_w;
  logic             irq_en;
  logic             act_set;
  irq_mode_e        mode_w;

  assign irq_en  = cfg_i[CFG_IEN] & cfg_i[CFG_LIST_IEN];
  assign mode_w  = cfg_i[CFG_LEVEL] ? IRQ_LEVEL : IRQ_PULSE;
  assign act_set = evt_i & irq_en;

  logic unused_bits;
  assign unused_bits = ^{cfg_i, reg_wdata_i};

  done_ctr #(.CNT_W(CNT_W)) done_i0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .done_o(done_w)
  );

  ack_reg #(.CNT_W(CNT_W)) ack_i0 (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i),
    .proc_wr_i(reg_wdata_i[PROC_LSB +: CNT_W]),
    .act_wr_i(reg_wdata_i[ACT_BIT]), .set_i(act_set),
    .proc_o(proc_w), .act_o(act_w)
  );

  chain_trk chain_i0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .start_i(chain_start_i),
    .loaded_o(list_loaded_o), .cmpl_o(cmpl_o)
  );

  irq_gen #(.CNT_W(CNT_W)) irq_i0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_i(irq_en), .mode_i(mode_w),
    .act_i(act_w), .done_i(done_w), .proc_i(proc_w),
    .irq_o(irq_o), .pending_o(pending_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[DONE_LSB +: CNT_W] = done_w;
    reg_rdata_o[ACT_BIT]           = act_w;
    reg_rdata_o[PROC_LSB +: CNT_W] = proc_w;
  end

  // R1
  collide_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && reg_wr_i |=> reg_rdata_o[DONE_LSB +: CNT_W] != $past(reg_rdata_o[DONE_LSB +: CNT_W]));
  // R5
  collide_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && irq_en && reg_wr_i |=> reg_rdata_o[ACT_BIT]);
endmodule

// File: tb/cmd_event_ctr_tb_top.sv
module cmd_event_ctr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt, cs, wr;
  logic [31:0] cfg, wd;
  logic [31:0] rdata;
  logic [5:0]  pend;
  logic        loaded, cmpl, irq;

  int checks = 0;
  int fails  = 0;

  logic [5:0] m_done, m_proc;
  logic       m_act, m_loaded, m_cmpl, m_evtq;

  always #4 clk = ~clk;

  cmd_event_ctr dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .chain_start_i(cs), .cfg_i(cfg),
    .reg_wr_i(wr), .reg_wdata_i(wd), .reg_rdata_o(rdata), .pending_o(pend),
    .list_loaded_o(loaded), .cmpl_o(cmpl), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic en, lvl, exp_irq;
    logic [31:0] exp_word;
    en  = cfg[29] & cfg[31];
    lvl = cfg[28];
    exp_irq = en & (lvl ? (m_act | (m_done != m_proc)) : m_evtq);
    exp_word = {10'd0, m_proc, 7'd0, m_act, 2'd0, m_done};
    chk(rdata[5:0] == m_done, "R1", "done field", 32'(rdata[5:0]), 32'(m_done));
    chk(rdata[21:16] == m_proc, "R4", "processed field", 32'(rdata[21:16]), 32'(m_proc));
    chk(rdata == exp_word, "R4", "status word", rdata, exp_word);
    chk(rdata[8] == m_act, "R5", "interrupt-active", 32'(rdata[8]), 32'(m_act));
    chk(pend == 6'(m_done - m_proc), "R2", "pending", 32'(pend), 32'(6'(m_done - m_proc)));
    chk(loaded == m_loaded, "R3", "list loaded", 32'(loaded), 32'(m_loaded));
    chk(cmpl == m_cmpl, "R3", "completion", 32'(cmpl), 32'(m_cmpl));
    chk(irq == exp_irq, lvl ? "R6" : "R7", "irq", 32'(irq), 32'(exp_irq));
  endtask

  task automatic step(input logic e, input logic w, input logic [31:0] d,
                      input logic c, input logic [31:0] cf);
    logic en, first;
    @(negedge clk);
    compare();
    evt = e; wr = w; wd = d; cs = c; cfg = cf;
    en = cf[29] & cf[31];
    first = e & (c | ~m_loaded);
    m_cmpl = e & ~first;
    m_evtq = e;
    if (e) m_loaded = 1'b1;
    else if (c) m_loaded = 1'b0;
    if (e && en) m_act = 1'b1;
    else if (w) m_act = d[8];
    if (w) m_proc = d[21:16];
    if (e) m_done = m_done + 6'd1;
  endtask

  function automatic logic [31:0] ack_word(input bit lag);
    logic [31:0] v;
    v = $urandom;
    v[21:16] = lag ? m_done - 6'd1 : m_done;
    v[8] = 1'b0;
    return v;
  endfunction

  function automatic bit chance(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lvl_on, pulse_on;
    lvl_on   = 32'hB000_0000;
    pulse_on = 32'hA000_0000;
    void'($urandom(7));
    rst_n = 1'b0; evt = 0; cs = 0; wr = 0; wd = '0; cfg = '0;
    m_done = 0; m_proc = 0; m_act = 0; m_loaded = 0; m_cmpl = 0; m_evtq = 0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(rdata == 32'd0, "R8", "status after reset", rdata, 32'd0);
    chk(irq == 1'b0, "R8", "irq after reset", 32'(irq), 32'd0);
    chk(loaded == 1'b0 && cmpl == 1'b0, "R8", "chain flags after reset",
        32'({loaded, cmpl}), 32'd0);
    rst_n = 1'b1;
    // R3 chain start then sparse events, level mode
    step(0, 0, '0, 1, lvl_on);
    for (int i = 0; i < 100; i++) step(chance(30), 0, '0, 0, lvl_on);
    // R1 wrap through 63 -> 0
    for (int i = 0; i < 70; i++) step(1, 0, '0, 0, lvl_on);
    // R4/R5 software acknowledges interleaved with events
    for (int i = 0; i < 400; i++) begin
      bit w;
      w = chance(20);
      step(chance(25), w, w ? ack_word(chance(30)) : 32'($urandom), 0, lvl_on);
    end
    // R1/R5 forced collisions of event and acknowledge
    for (int i = 0; i < 50; i++) step(1, 1, ack_word(0), 0, lvl_on);
    for (int i = 0; i < 5; i++) step(0, 1, ack_word(0), 0, lvl_on);
    // R7 interrupts disabled by either enable bit
    for (int i = 0; i < 200; i++)
      step(chance(30), chance(20), $urandom, 0, (i < 100) ? 32'h9000_0000 : 32'h3000_0000);
    // R7 pulse mode
    for (int i = 0; i < 200; i++) step(chance(40), chance(15), ack_word(0), 0, pulse_on);
    // R3 frequent chain restarts
    for (int i = 0; i < 300; i++) step(chance(50), chance(10), ack_word(0), chance(10), lvl_on);
    // all modes, fully random stimulus
    for (int i = 0; i < 400; i++) step(chance(40), chance(25), $urandom, chance(5), $urandom);
    step(0, 0, '0, 0, lvl_on);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule